// File: doc/BRIEF.md
# Post-Code Hex Text Logger

This block captures one-byte power-on progress codes handed over by a bus slave and turns them into plain text on a serial line, so that a terminal shows the boot progress of a target board. Each byte is written into an internal byte queue. A formatter takes the bytes out in order and turns each into a short hex token. An 8N1 transmitter sends the characters.

The queue occupancy is exported all the time for a numeric status display. Serial output is much slower than the rate at which a bus can write codes, so the block raises a stall signal toward the producer when the queue reaches a fixed level. The producer then holds its write until the stall clears, and no code is lost.

Top module: `postcode_logger`

## Requirements
- R1: Every logged byte produces the character 'x' (0x78) followed by two hex digit characters, the high nibble first.
- R2: Nibble values 0 to 9 map to 0x30 to 0x39, and values 10 to 15 map to uppercase 'A' to 'F' (0x41 to 0x46).
- R3: A single space (0x20) precedes every byte that is not the first of its line. The first byte of a line has no space before it.
- R4: Once the LINE_BYTES-th byte of a line (default 16) has been sent, CR (0x0D) and then LF (0x0A) follow with no trailing space, and the next byte opens a new line.
- R5: Characters go out as 8N1 frames: a low start bit, eight data bits LSB first, and a high stop bit. Each bit lasts round(CLK_HZ/BAUD) clocks, and the line rests high when idle. A character offered to the transmitter stays stable until it is taken.
- R6: A byte on code_i is taken at a rising clock edge where code_valid_i is 1 and stall_o is 0. Taken bytes are emitted in arrival order, none is lost, and a write held off by stall_o changes nothing.
- R7: level_o gives the number of bytes in the queue that the formatter has not yet taken. It rises by one at the edge that takes a byte, when no byte leaves at that same edge.
- R8: stall_o is 1 exactly while level_o is at least STALL_LEVEL (default 0x1F40), and it falls once the level drops below that value.
- R9: Reset (rst_ni low, asynchronous) empties the queue, drives txd_o high and stall_o low, and clears the line position, so the first byte after reset starts a line with no leading space.
- R10: level_o never exceeds STALL_LEVEL. STALL_LEVEL must not exceed DEPTH (default 8192).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_valid_i | input | 1 | Producer offers a code byte |
| code_i | input | 8 | Code byte |
| stall_o | output | 1 | Queue at stall level; producer must hold its write |
| level_o | output | $clog2(DEPTH+1) | Bytes waiting in the queue |
| txd_o | output | 1 | Serial text output, idles high |

## Verification
level_o and stall_o reflect a write at the edge that accepts it. The bench drives inputs on falling edges and reads stall_o before the edge to decide whether the write was taken, so its level model moves in step with the design. For example, four back-to-back writes into an idle block leave a level of three after the fourth edge, because the formatter takes the first byte one edge after it lands. Serial characters arrive hundreds of cycles later. A bench receiver finds each start-bit fall, samples every bit at its midpoint in multiples of the bit period, and compares the character against a queue that the bench built from the accepted bytes.

// File: rtl/postcode_logger_pkg.sv
package postcode_logger_pkg;

  typedef enum logic [2:0] {
    FMT_IDLE,
    FMT_SEP,
    FMT_X,
    FMT_HI,
    FMT_LO,
    FMT_CR,
    FMT_LF
  } fmt_state_e;

  localparam logic [7:0] CH_X  = 8'h78;
  localparam logic [7:0] CH_SP = 8'h20;
  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_LF = 8'h0A;

  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

endpackage

// File: rtl/pcl_fifo.sv
module pcl_fifo #(
  parameter int DEPTH       = 8192,
  parameter int STALL_LEVEL = 8000,
  parameter int LVL_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             rd_i,
  output logic [7:0]       rd_data_o,
  output logic             empty_o,
  output logic             stall_o,
  output logic             push_o,
  output logic             pop_o,
  output logic [LVL_W-1:0] level_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit POW2 = (DEPTH == (1 << AW));

  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [LVL_W-1:0] count;

  assign stall_o = count >= LVL_W'(STALL_LEVEL);
  assign empty_o = count == '0;
  assign push_o  = wr_i && !stall_o;
  assign pop_o   = rd_i && !empty_o;
  assign level_o = count;
  assign rd_data_o = mem[rd_ptr];

  generate
    if (POW2) begin : g_wrap_nat
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (push_o) mem[wr_ptr] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_o) wr_ptr <= wr_nxt;
      if (pop_o)  rd_ptr <= rd_nxt;
      case ({push_o, pop_o})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pcl_fmt.sv
module pcl_fmt
  import postcode_logger_pkg::*;
#(
  parameter int LINE_BYTES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       empty_i,
  input  logic [7:0] data_i,
  output logic       pop_o,
  output logic       ch_valid_o,
  output logic [7:0] ch_o,
  input  logic       ch_ready_i
);
  localparam int LW = $clog2(LINE_BYTES + 1);

  fmt_state_e    state;
  logic [7:0]    byte_q;
  logic [LW-1:0] line_cnt;
  logic          take;

  assign pop_o      = (state == FMT_IDLE) && !empty_i;
  assign ch_valid_o = (state != FMT_IDLE);
  assign take       = ch_valid_o && ch_ready_i;

  always_comb begin
    case (state)
      FMT_SEP: ch_o = CH_SP;
      FMT_X:   ch_o = CH_X;
      FMT_HI:  ch_o = nib_to_ascii(byte_q[7:4]);
      FMT_LO:  ch_o = nib_to_ascii(byte_q[3:0]);
      FMT_CR:  ch_o = CH_CR;
      FMT_LF:  ch_o = CH_LF;
      default: ch_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= FMT_IDLE;
      byte_q   <= '0;
      line_cnt <= '0;
    end else if (state == FMT_IDLE) begin
      if (!empty_i) begin
        byte_q <= data_i;
        state  <= (line_cnt == '0) ? FMT_X : FMT_SEP;
      end
    end else if (take) begin
      case (state)
        FMT_SEP: state <= FMT_X;
        FMT_X:   state <= FMT_HI;
        FMT_HI:  state <= FMT_LO;
        FMT_LO: begin
          if (line_cnt == LW'(LINE_BYTES - 1)) begin
            line_cnt <= '0;
            state    <= FMT_CR;
          end else begin
            line_cnt <= line_cnt + 1'b1;
            state    <= FMT_IDLE;
          end
        end
        FMT_CR:  state <= FMT_LF;
        default: state <= FMT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcl_uart_tx.sv
module pcl_uart_tx #(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       ready_o,
  output logic       txd_o
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);

  logic [9:0]    shreg;
  logic [3:0]    bit_cnt;
  logic [CW-1:0] baud_cnt;
  logic          busy;

  assign ready_o = !busy;
  assign txd_o   = shreg[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg    <= '1;
      bit_cnt  <= '0;
      baud_cnt <= '0;
      busy     <= 1'b0;
    end else if (!busy) begin
      if (valid_i) begin
        shreg    <= {1'b1, data_i, 1'b0};
        bit_cnt  <= '0;
        baud_cnt <= '0;
        busy     <= 1'b1;
      end
    end else if (baud_cnt == CW'(CLKS_PER_BIT - 1)) begin
      baud_cnt <= '0;
      shreg    <= {1'b1, shreg[9:1]};
      if (bit_cnt == 4'd9) busy <= 1'b0;
      else bit_cnt <= bit_cnt + 1'b1;
    end else begin
      baud_cnt <= baud_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/postcode_logger.sv
module postcode_logger #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int BAUD        = 115_200,
  parameter int DEPTH       = 8192,
  parameter int STALL_LEVEL = 8000,
  parameter int LINE_BYTES  = 16,
  localparam int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             code_valid_i,
  input  logic [7:0]       code_i,
  output logic             stall_o,
  output logic [LVL_W-1:0] level_o,
  output logic             txd_o
);
  localparam int CLKS_PER_BIT = (CLK_HZ + BAUD / 2) / BAUD;

  logic [7:0] fifo_data;
  logic       fifo_empty, fifo_rd, fifo_push, fifo_pop;
  logic       ch_valid, ch_ready;
  logic [7:0] ch_data;

  pcl_fifo #(
    .DEPTH(DEPTH), .STALL_LEVEL(STALL_LEVEL), .LVL_W(LVL_W)
  ) u_fifo (
    .clk_i, .rst_ni,
    .wr_i(code_valid_i), .wr_data_i(code_i),
    .rd_i(fifo_rd), .rd_data_o(fifo_data),
    .empty_o(fifo_empty), .stall_o(stall_o),
    .push_o(fifo_push), .pop_o(fifo_pop),
    .level_o(level_o)
  );

  pcl_fmt #(.LINE_BYTES(LINE_BYTES)) u_fmt (
    .clk_i, .rst_ni,
    .empty_i(fifo_empty), .data_i(fifo_data), .pop_o(fifo_rd),
    .ch_valid_o(ch_valid), .ch_o(ch_data), .ch_ready_i(ch_ready)
  );

  pcl_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk_i, .rst_ni,
    .valid_i(ch_valid), .data_i(ch_data),
    .ready_o(ch_ready), .txd_o(txd_o)
  );
endmodule

// File: rtl/postcode_logger_chk.sv
module postcode_logger_chk #(
  parameter int STALL_LEVEL = 8000,
  parameter int LVL_W       = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             code_valid_i,
  input logic             stall_o,
  input logic [LVL_W-1:0] level_o,
  input logic             pop_i,
  input logic             ch_valid_i,
  input logic             ch_ready_i,
  input logic [7:0]       ch_data_i
);
  assert_push_counts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_valid_i && !stall_o && !pop_i) |=> (level_o == $past(level_o) + 1'b1));

  assert_stalled_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_valid_i && stall_o && !pop_i) |=> (level_o == $past(level_o)));

  assert_pop_nonempty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (level_o != '0));

  assert_level_cap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(STALL_LEVEL));

  assert_stall_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> (level_o == LVL_W'(STALL_LEVEL)));

  assert_hold_char_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_valid_i && !ch_ready_i) |=> (ch_valid_i && $stable(ch_data_i)));
endmodule

bind postcode_logger postcode_logger_chk #(
  .STALL_LEVEL(STALL_LEVEL), .LVL_W(LVL_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .code_valid_i(code_valid_i),
  .stall_o(stall_o), .level_o(level_o), .pop_i(fifo_pop),
  .ch_valid_i(ch_valid), .ch_ready_i(ch_ready), .ch_data_i(ch_data)
);

// File: tb/postcode_logger_tb.sv
module postcode_logger_tb;
  localparam int CLK_HZ = 50_000_000;
  localparam int BAUD   = 6_250_000;
  localparam int CPB    = (CLK_HZ + BAUD / 2) / BAUD;
  localparam int DEPTH  = 64;
  localparam int STALL  = 48;
  localparam int LINE   = 16;
  localparam int LVL_W  = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             code_valid = 1'b0;
  logic [7:0]       code = '0;
  logic             stall;
  logic [LVL_W-1:0] level;
  logic             txd;

  int n_chk = 0, n_bad = 0;
  int line_pos = 0;
  bit stall_seen = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  postcode_logger #(
    .CLK_HZ(CLK_HZ), .BAUD(BAUD), .DEPTH(DEPTH),
    .STALL_LEVEL(STALL), .LINE_BYTES(LINE)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .code_valid_i(code_valid), .code_i(code),
    .stall_o(stall), .level_o(level), .txd_o(txd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n);
    return (n < 10) ? 8'h30 + 8'(n) : 8'h41 + 8'(n) - 8'd10;
  endfunction

  task automatic model_byte(input logic [7:0] b);
    if (line_pos != 0) begin exp_q.push_back(8'h20); tag_q.push_back("R3"); end
    exp_q.push_back(8'h78);        tag_q.push_back("R1");
    exp_q.push_back(hexc(b[7:4])); tag_q.push_back("R2");
    exp_q.push_back(hexc(b[3:0])); tag_q.push_back("R2");
    line_pos++;
    if (line_pos == LINE) begin
      exp_q.push_back(8'h0D); tag_q.push_back("R4");
      exp_q.push_back(8'h0A); tag_q.push_back("R4");
      line_pos = 0;
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance (R6)
  task automatic push_byte(input logic [7:0] b);
    bit acc;
    code_valid = 1'b1;
    code = b;
    forever begin
      acc = !stall;
      @(negedge clk);
      if (acc) break;
    end
    code_valid = 1'b0;
    model_byte(b);
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3 * CPB) @(negedge clk);
    check(exp_q.size() == 0, "R6 all chars out", exp_q.size(), 0);
    check(level == 0, "R7 drained level", level, 0);
  endtask

  task automatic check_reset_state();
    check(txd == 1'b1, "R9 txd idle", txd, 1);
    check(stall == 1'b0, "R9 stall", stall, 0);
    check(level == 0, "R9 level", level, 0);
  endtask

  // serial receiver (R5)
  initial begin
    logic [7:0] d;
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        repeat (CPB / 2) @(negedge clk);
        check(txd == 1'b0, "R5 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          d[i] = txd;
        end
        repeat (CPB) @(negedge clk);
        check(txd == 1'b1, "R5 stop bit", txd, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected char", d, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(d == e, t, d, e);
        end
      end
    end
  end

  // level/stall monitor (R8, R10)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stall) stall_seen = 1;
        check(stall == (level >= STALL), "R8 stall vs level", stall, level >= STALL);
        check(level <= STALL, "R10 level cap", level, STALL);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0 pending", exp_q.size());
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners: digits, uppercase hex, level count (R2, R7)
    push_byte(8'h00);
    push_byte(8'hAB);
    push_byte(8'hFF);
    push_byte(8'h5C);
    check(level == 3, "R7 level after burst", level, 3);
    drain();

    // line wrap across 16 bytes (R4)
    for (int i = 0; i < 17; i++) push_byte(8'(i * 8'h13 + 8'h09));
    drain();

    // reset with a partial line pending (R9)
    rst_n = 1'b0;
    line_pos = 0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    push_byte(8'h3C);
    push_byte(8'hE7);
    drain();

    // burst past the stall level (R8, R6)
    stall_seen = 0;
    for (int i = 0; i < 60; i++) push_byte(8'($urandom));
    check(stall_seen, "R8 stall raised", stall_seen, 1);
    drain();
    check(stall == 1'b0, "R8 stall released", stall, 0);

    // random bytes with random gaps
    for (int i = 0; i < 40; i++) begin
      push_byte(8'($urandom));
      repeat ($urandom % 400) @(negedge clk);
    end
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule